// File: doc/BRIEF.md
# Start/Stop Framed Single-Wire Serial Transmitter

This block takes 8-bit words from a local 16-entry FIFO and sends each one on a single serial wire. No separate strobe or clock travels with the data. Every word goes out as a 10-bit frame made of a '1' start bit, the eight data bits least significant first, and a '0' stop bit. A receiver that watches for a low-to-high edge on an idle-low line can then find the beginning of each frame.

Bit timing comes from a `bit_tick` clock enable, and each tick moves the line by one bit. A run flag starts transmission. It is set whenever the FIFO holds data and cleared at a frame boundary once the FIFO is empty. A one-hot ring counter marks the frame boundary. Words that are waiting go out back to back with no idle bits between them. When the FIFO drains, the line rests at 0.

Top module: `framed_line_tx`

## Requirements
- R1: After reset `line_out` is 0 and `full` is 0.
- R2: Each word is sent as 10 consecutive bit periods, one per `bit_tick`. The first period is 1 (start). Periods 2 to 9 carry data bit 0 up to data bit 7. Period 10 is 0 (stop).
- R3: `line_out` changes only on a clock edge where `bit_tick` is 1. In a cycle without a tick it holds its value.
- R4: When the stop bit has gone out and the FIFO is empty, the line parks at 0 for all further ticks until a new word is written.
- R5: If another word is waiting when a stop bit ends, its start bit goes out on the very next tick, with no idle period.
- R6: The FIFO holds 16 words, and `full` is 1 exactly when 16 words are stored and not yet sent.
- R7: A write while `full` is 1 is dropped. The dropped word never appears on the line.
- R8: Words are sent in the order they were written.
- R9: Once a word has been written into an idle transmitter, the first tick at least two clock cycles after the write sends its start bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the word FIFO |
| wr_data | input | 8 | Word to be queued |
| full | output | 1 | FIFO holds 16 words; writes are dropped |
| bit_tick | input | 1 | Bit-period clock enable |
| line_out | output | 1 | Registered serial line, idle low |

## Verification
The bench goes after the bit order inside a frame. A design that sends the most significant bit first, or leaves out the start or stop bit, fails the per-bit comparison for patterns such as 0x01 and 0x80. It checks that a queue of sixteen words leaves the line back to back, in order. A one-bit gap between frames, or a missed frame boundary in the ring counter, shifts every later bit and so makes those checks fail. It also writes into a full FIFO and ticks past the end of the queue. A design that accepted the extra word, or that failed to park the line low, would put a seventeenth frame or a stray 1 on the line. It also holds `bit_tick` low in the middle of a frame, which catches a design that advances on plain clock edges.

// File: rtl/ftx_pkg.sv
package ftx_pkg;
  parameter int unsigned WORD_W     = 8;
  parameter int unsigned FIFO_DEPTH = 16;

  // Frame layout, bit 0 leaves first: start '1', data LSB first, stop '0'.
  function automatic logic [WORD_W+1:0] make_frame(input logic [WORD_W-1:0] w);
    return {1'b0, w, 1'b1};
  endfunction
endpackage

// File: rtl/ftx_word_fifo.sv
module ftx_word_fifo #(
  parameter int unsigned W     = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_req,
  input  logic [W-1:0] push_data,
  input  logic         pop,
  output logic [W-1:0] pop_data,
  output logic         empty,
  output logic         full
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0] count_q, count_d;
  logic          push_ok;

  assign full     = (count_q == CW'(DEPTH));
  assign empty    = (count_q == '0);
  assign push_ok  = push_req && !full;
  assign pop_data = mem[rd_ptr_q];

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    if (push_ok) begin
      wr_ptr_d = (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
    end
    if (pop && !empty) begin
      rd_ptr_d = (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;
    end
    case ({push_ok, pop && !empty})
      2'b10:   count_d = count_q + 1'b1;
      2'b01:   count_d = count_q - 1'b1;
      default: count_d = count_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr_q] <= push_data;
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push_req && full && !pop) |=> $stable(count_q)); // R7
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CW'(DEPTH)); // R6
endmodule

// File: rtl/ftx_ring.sv
module ftx_ring #(
  parameter int unsigned LEN = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           advance,
  output logic           at_home,
  output logic [LEN-1:0] pos
);
  logic [LEN-1:0] ring_q, ring_d;

  always_comb begin
    ring_d = ring_q;
    if (advance) ring_d = {ring_q[0], ring_q[LEN-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ring_q <= LEN'(1);
    else        ring_q <= ring_d;
  end

  assign pos     = ring_q;
  assign at_home = ring_q[0];

  AST_RING_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(ring_q) == 1); // R2
endmodule

// File: rtl/ftx_shifter.sv
module ftx_shifter #(
  parameter int unsigned LEN = 10
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic           shift,
  input  logic [LEN-1:0] frame,
  output logic           line
);
  logic [LEN-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load)       sh_d = frame;
    else if (shift) sh_d = {1'b0, sh_q[LEN-1:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign line = sh_q[0];

  AST_START_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> line); // R2
  AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !shift) |=> $stable(line)); // R3
endmodule

// File: rtl/framed_line_tx.sv
module framed_line_tx #(
  parameter int unsigned WORD_W     = ftx_pkg::WORD_W,
  parameter int unsigned FIFO_DEPTH = ftx_pkg::FIFO_DEPTH
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic              full,
  input  logic              bit_tick,
  output logic              line_out
);
  localparam int unsigned FRAME_LEN = WORD_W + 2;

  logic                 empty;
  logic [WORD_W-1:0]    head_word;
  logic                 run_q, run_d;
  logic                 at_home;
  logic [FRAME_LEN-1:0] ring_pos;
  logic                 advance, load, shift;
  logic [FRAME_LEN-1:0] frame;

  ftx_word_fifo #(.W(WORD_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n),
    .push_req(wr_en), .push_data(wr_data),
    .pop(load), .pop_data(head_word),
    .empty(empty), .full(full)
  );

  // Starter: set by pending data, cleared at a frame boundary once drained.
  always_comb begin
    run_d = run_q;
    if (!run_q && !empty)               run_d = 1'b1;
    else if (run_q && at_home && empty) run_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_d;
  end

  assign advance = bit_tick && run_q && (!at_home || !empty);
  assign load    = advance && at_home;
  assign shift   = advance && !at_home;
  assign frame   = ftx_pkg::make_frame(head_word);

  ftx_ring #(.LEN(FRAME_LEN)) u_ring (
    .clk(clk), .rst_n(rst_n),
    .advance(advance), .at_home(at_home), .pos(ring_pos)
  );

  ftx_shifter #(.LEN(FRAME_LEN)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .load(load), .shift(shift), .frame(frame), .line(line_out)
  );

  AST_QUIET_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(line_out)); // R3
  AST_PARK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !line_out); // R4
  AST_START_AT_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run_q) |-> ring_pos[0]); // R9
  AST_STOP_BEFORE_HOME: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && ring_pos[0]) |-> !line_out); // R5
endmodule

// File: tb/framed_line_tx_tb.sv
`timescale 1ns/1ps
module framed_line_tx_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       bit_tick = 1'b0;
  logic       full;
  logic       line_out;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  localparam logic [7:0] VEC [0:5] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h01, 8'h80};

  always #4 clk = ~clk;

  framed_line_tx u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .full(full), .bit_tick(bit_tick), .line_out(line_out)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic put(input logic [7:0] w);
    @(negedge clk); wr_en = 1'b1; wr_data = w;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick;
    @(negedge clk); bit_tick = 1'b1;
    @(negedge clk); bit_tick = 1'b0;
  endtask

  // R2 frame: start 1, data LSB first, stop 0; R8 order is implied by caller's word.
  task automatic expect_frame(input logic [7:0] w, input string req);
    tick(); check({req, " start"}, line_out, 1'b1);
    for (int b = 0; b < 8; b++) begin
      tick(); check({req, " data"}, line_out, w[b]);
    end
    tick(); check({req, " stop"}, line_out, 1'b0);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    check("R1 line", line_out, 1'b0);
    check("R1 full", full, 1'b0);

    // Vector table walk: one word per pass, then park check.
    for (int i = 0; i < 6; i++) begin
      put(VEC[i]);
      idle(2);
      expect_frame(VEC[i], "R2_R9");
      tick(); check("R4 park", line_out, 1'b0);
      tick(); check("R4 park", line_out, 1'b0);
    end

    // R3: no tick mid-frame leaves the line unchanged.
    put(8'b0000_0110);
    idle(2);
    tick(); check("R3 start", line_out, 1'b1);
    tick(); check("R3 d0", line_out, 1'b0);
    tick(); check("R3 d1", line_out, 1'b1);
    idle(7); check("R3 hold", line_out, 1'b1);
    for (int b = 2; b < 8; b++) begin
      tick(); check("R3 data", line_out, (b == 2));
    end
    tick(); check("R3 stop", line_out, 1'b0);
    tick(); check("R4 park", line_out, 1'b0);

    // R3: idle transmitter with data queued but no tick stays low.
    put(8'h3C);
    idle(12); check("R3 no tick", line_out, 1'b0);
    expect_frame(8'h3C, "R9");
    tick(); check("R4 park", line_out, 1'b0);

    // R6/R7/R8/R5: fill 16, overflow write, drain back to back.
    for (int i = 0; i < 15; i++) put(8'(i * 17 + 3));
    check("R6 not full at 15", full, 1'b0);
    put(8'(15 * 17 + 3));
    check("R6 full at 16", full, 1'b1);
    put(8'hE7);
    check("R7 still full", full, 1'b1);
    idle(2);
    for (int i = 0; i < 16; i++) begin
      expect_frame(8'(i * 17 + 3), "R5_R8");
      if (i == 0) check("R6 full cleared", full, 1'b0);
    end
    for (int k = 0; k < 12; k++) begin
      tick(); check("R7_R4 no dropped word", line_out, 1'b0);
    end

    // R1: reset mid-frame returns line low.
    put(8'hFF);
    idle(2);
    tick(); tick();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); check("R1 reset line", line_out, 1'b0);
    check("R1 reset full", full, 1'b0);
    rst_n = 1'b1;
    tick(); check("R1 empty after reset", line_out, 1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule